// File: doc/BRIEF.md
# Two-Stage Lockable Watchdog Timer

A watchdog that sits on a simple register bus and must be kicked periodically by software. A 32-bit down-counter advances once every sixteen clock cycles while the watchdog is enabled. When the count first runs out, the block raises an interrupt and starts the count again from the load value. If software has still not cleared that interrupt when the count runs out a second time, the block raises a system reset request. The reset request holds until the block's own asynchronous reset is applied.

A write lock guards every register except the lock register itself. Software opens the lock by writing the 32-bit key 0x1ACCE551 to the lock register. It closes the lock again by writing any other value. A typical sequence unlocks the block, programs the load value, clears the interrupt, enables the block and locks it again. A load value of zero with both enables set makes the reset occur within three counter steps. Software uses this to force an immediate reset.

Top module: `lock_wdt`

## Requirements
- R1: After reset, the load register (offset 0x000), the count (offset 0x004) and the control register (offset 0x008) read 0. The lock register (offset 0xC00) reads 1. `irq_o` and `sys_rst_req_o` are low.
- R2: A write of 0x1ACCE551 to offset 0xC00 unlocks the block, and the lock register then reads 0. A write of any other value to offset 0xC00 locks the block, and the lock register then reads 1. Writes to the lock register are accepted whether the block is locked or unlocked.
- R3: While the block is locked, writes to offsets 0x000, 0x008 and 0x00C have no effect.
- R4: While control bit 0 is set, the count changes only on every sixteenth clock. The first step comes 16 clocks after the enabling write.
- R5: On the first counter step after the block is enabled, or after an unlocked write to offset 0x000 or 0x00C, the count is set to the load value. After that, each step lowers the count by one.
- R6: A step taken while the count is 0 sets the pending interrupt, and `irq_o` follows it while control bit 0 is set. The same step reloads the count from the load value. With load value L, the first interrupt rises on step L+2.
- R7: An unlocked write of any value to offset 0x00C clears the pending interrupt and restarts the count. Kicks that come closer together than one timeout keep `irq_o` low.
- R8: With control bit 1 set, an expiry that finds the interrupt still pending raises `sys_rst_req_o`. The request stays high, even after the block is disabled, until `rst_ni` is asserted.
- R9: With control bit 1 clear, the second expiry leaves `sys_rst_req_o` low and the interrupt stays pending.
- R10: Writing 0 to the control register stops the watchdog. The count holds, and neither the interrupt nor the reset request can occur.
- R11: With a load value of 0 and control set to 3, `irq_o` rises 32 clocks after the control write and `sys_rst_req_o` rises 48 clocks after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and counter clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 12 | Register byte offset |
| we_i | input | 1 | Write strobe, one write per cycle |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Pending first-stage interrupt |
| sys_rst_req_o | output | 1 | Sticky system reset request |

## Verification
The register-access table runs the block through several lock states. It writes to the same registers with the lock closed, opened by the exact key, opened by a key that differs in one bit, and closed again. This shows whether the lock gate sits on the right offsets and whether the key is compared on all 32 bits. Timed runs cover four cases: a large load value, to find the prescaler phase and the first reload; a small load value with the reset disabled, to separate the first expiry from the second; a load value of zero with the reset enabled, where both stages fall on exact clock counts; and a stream of kicks that must keep the interrupt from ever rising. Disabling the block in the middle of a count, and a reset request made before the block is disabled, show that the stop is clean and that the reset request is sticky.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam logic [ADDR_W-1:0] OFS_LOAD  = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_COUNT = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_KICK  = 12'h00C;
  localparam logic [ADDR_W-1:0] OFS_LOCK  = 12'hC00;
  localparam logic [31:0]       UNLOCK_KEY = 32'h1ACC_E551;

  typedef struct packed {
    logic rst_en;
    logic run_en;
  } ctrl_t;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned DIV = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned PW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          div_q <= '0;
    else if (!en_i)       div_q <= '0;
    else if (div_q == LAST) div_q <= '0;
    else                  div_q <= div_q + 1'b1;
  end

  assign tick_o = en_i && (div_q == LAST);
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             reload_req_i,
  input  logic [CNT_W-1:0] load_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             pend_q;   // reload owed on the next tick
  logic             at_zero;

  assign at_zero = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_q <= 1'b1;
    end else begin
      if (tick_i) cnt_q <= (pend_q || at_zero) ? load_i : cnt_q - 1'b1;
      if (reload_req_i || !en_i) pend_q <= 1'b1;
      else if (tick_i)           pend_q <= 1'b0;
    end
  end

  // a kick in the expiry cycle wins
  assign expire_o = tick_i && !pend_q && at_zero && !reload_req_i;
  assign cnt_o    = cnt_q;
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              expire_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [CNT_W-1:0]  load_o,
  output ctrl_t             ctrl_o,
  output logic              locked_o,
  output logic              reload_req_o,
  output logic              irq_o,
  output logic              sys_rst_req_o
);
  logic [CNT_W-1:0] load_q;
  ctrl_t            ctrl_q;
  logic             locked_q, irq_q, rst_q;
  logic             wr_ok, kick_wr, load_wr, ctrl_wr, lock_wr;

  assign wr_ok   = we_i && !locked_q;
  assign load_wr = wr_ok && (addr_i == OFS_LOAD);
  assign ctrl_wr = wr_ok && (addr_i == OFS_CTRL);
  assign kick_wr = wr_ok && (addr_i == OFS_KICK);
  assign lock_wr = we_i  && (addr_i == OFS_LOCK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q   <= '0;
      ctrl_q   <= '0;
      locked_q <= 1'b1;
      irq_q    <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      if (load_wr) load_q   <= wdata_i[CNT_W-1:0];
      if (ctrl_wr) ctrl_q   <= ctrl_t'(wdata_i[1:0]);
      if (lock_wr) locked_q <= (wdata_i != UNLOCK_KEY);
      if (kick_wr)       irq_q <= 1'b0;
      else if (expire_i) irq_q <= 1'b1;
      if (expire_i && irq_q && ctrl_q.rst_en) rst_q <= 1'b1;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFS_LOAD:  rdata_o = 32'(load_q);
      OFS_COUNT: rdata_o = 32'(cnt_i);
      OFS_CTRL:  rdata_o = {30'd0, ctrl_q};
      OFS_LOCK:  rdata_o = {31'd0, locked_q};
      default:   rdata_o = '0;
    endcase
  end

  assign load_o        = load_q;
  assign ctrl_o        = ctrl_q;
  assign locked_o      = locked_q;
  assign reload_req_o  = load_wr || kick_wr;
  assign irq_o         = irq_q && ctrl_q.run_en;
  assign sys_rst_req_o = rst_q;
endmodule

// File: rtl/lock_wdt.sv
module lock_wdt
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned DIV   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o,
  output logic              sys_rst_req_o
);
  logic [CNT_W-1:0] load, cnt;
  ctrl_t            ctrl;
  logic             tick, expire, reload_req, locked;

  wdt_prescaler #(.DIV(DIV)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (ctrl.run_en),
    .tick_o (tick)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (ctrl.run_en),
    .tick_i       (tick),
    .reload_req_i (reload_req),
    .load_i       (load),
    .cnt_o        (cnt),
    .expire_o     (expire)
  );

  wdt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .addr_i        (addr_i),
    .we_i          (we_i),
    .wdata_i       (wdata_i),
    .rdata_o       (rdata_o),
    .expire_i      (expire),
    .cnt_i         (cnt),
    .load_o        (load),
    .ctrl_o        (ctrl),
    .locked_o      (locked),
    .reload_req_o  (reload_req),
    .irq_o         (irq_o),
    .sys_rst_req_o (sys_rst_req_o)
  );
endmodule

// File: rtl/lock_wdt_chk.sv
module lock_wdt_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             we_i,
  input logic [11:0]      addr_i,
  input logic             locked,
  input logic             tick,
  input logic             run_en,
  input logic [CNT_W-1:0] load,
  input logic [CNT_W-1:0] cnt,
  input logic             irq_o,
  input logic             sys_rst_req_o
);
  p_locked_load_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked && we_i && addr_i == 12'h000) |=> $stable(load));

  p_tick_gap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |=> !tick);

  p_irq_on_tick_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(irq_o) && $past(run_en)) |-> $past(tick));

  p_rst_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_req_o |=> sys_rst_req_o);

  p_rst_after_irq_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_req_o) |-> $past(irq_o));

  p_stopped_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_en |=> $stable(cnt));
endmodule

bind lock_wdt lock_wdt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .we_i          (we_i),
  .addr_i        (addr_i),
  .locked        (locked),
  .tick          (tick),
  .run_en        (ctrl.run_en),
  .load          (load),
  .cnt           (cnt),
  .irq_o         (irq_o),
  .sys_rst_req_o (sys_rst_req_o)
);

// File: tb/lock_wdt_tb.sv
module lock_wdt_tb;
  localparam logic [11:0] A_LOAD = 12'h000, A_CNT = 12'h004, A_CTRL = 12'h008,
                          A_KICK = 12'h00C, A_LOCK = 12'hC00;
  localparam logic [31:0] KEY = 32'h1ACC_E551;

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  // register-access table: R1 reset reads, R2 lock key, R3 locked writes
  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{1'b0, A_LOCK, 32'h0,        32'h1,  4'd1},
    '{1'b0, A_LOAD, 32'h0,        32'h0,  4'd1},
    '{1'b0, A_CTRL, 32'h0,        32'h0,  4'd1},
    '{1'b1, A_LOAD, 32'h55,       32'h0,  4'd3},
    '{1'b0, A_LOAD, 32'h0,        32'h0,  4'd3},
    '{1'b1, A_CTRL, 32'h2,        32'h0,  4'd3},
    '{1'b0, A_CTRL, 32'h0,        32'h0,  4'd3},
    '{1'b1, A_LOCK, 32'h1ACCE550, 32'h0,  4'd2},
    '{1'b0, A_LOCK, 32'h0,        32'h1,  4'd2},
    '{1'b1, A_LOCK, KEY,          32'h0,  4'd2},
    '{1'b0, A_LOCK, 32'h0,        32'h0,  4'd2},
    '{1'b1, A_LOAD, 32'h55,       32'h0,  4'd2},
    '{1'b0, A_LOAD, 32'h0,        32'h55, 4'd2},
    '{1'b1, A_CTRL, 32'h2,        32'h0,  4'd2},
    '{1'b0, A_CTRL, 32'h0,        32'h2,  4'd2},
    '{1'b1, A_LOCK, 32'h1,        32'h0,  4'd2},
    '{1'b0, A_LOCK, 32'h0,        32'h1,  4'd2},
    '{1'b1, A_LOAD, 32'h7,        32'h0,  4'd3},
    '{1'b0, A_LOAD, 32'h0,        32'h55, 4'd3},
    '{1'b1, A_CTRL, 32'h0,        32'h0,  4'd3},
    '{1'b0, A_CTRL, 32'h0,        32'h2,  4'd3}
  };

  logic        clk = 1'b0, rst_n = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        irq, srst;
  int          n_chk = 0, n_err = 0, cyc = 0;

  always #5 clk = ~clk;

  lock_wdt u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq), .sys_rst_req_o(srst)
  );

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: run hung, got %0d expected < 150000 cycles", cyc);
      finish_run();
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  logic [31:0] v, v2;

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);

    // R1 outputs after reset
    check("R1 irq", 32'(irq), 0);
    check("R1 rst_req", 32'(srst), 0);
    rd(A_CNT, v); check("R1 count", v, 0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) wr(VEC[i].addr, VEC[i].data);
      else begin
        rd(VEC[i].addr, v);
        check($sformatf("R%0d vec%0d", VEC[i].req, i), v, VEC[i].exp);
      end
    end

    // R3 kick while locked must not clear a pending irq: checked in R7 block below
    wr(A_LOCK, KEY);
    wr(A_CTRL, 0);

    // R4 R5: prescaler phase and first reload
    wr(A_LOAD, 100);
    wr(A_CTRL, 1);
    wait_cyc(15); rd(A_CNT, v); check("R4 no step before 16 clocks", v, 0);
    wait_cyc(1);  rd(A_CNT, v); check("R5 reload on first step", v, 100);
    wait_cyc(15); rd(A_CNT, v); check("R4 holds between steps", v, 100);
    wait_cyc(1);  rd(A_CNT, v); check("R5 decrement", v, 99);

    // R10 stop mid-count
    wr(A_CTRL, 0);
    rd(A_CNT, v);
    wait_cyc(100);
    rd(A_CNT, v2); check("R10 count holds", v2, v);
    check("R10 no irq", 32'(irq), 0);

    // R6 R9 R7: load 2, reset disabled
    wr(A_LOAD, 2);
    wr(A_CTRL, 1);
    wait_cyc(63); check("R6 irq low before step L+2", 32'(irq), 0);
    wait_cyc(1);  check("R6 irq at step L+2", 32'(irq), 1);
    rd(A_CNT, v); check("R6 reload at expiry", v, 2);
    wait_cyc(60); check("R9 no reset when disabled", 32'(srst), 0);
    check("R9 irq still pending", 32'(irq), 1);
    wr(A_LOCK, 32'h0);
    wr(A_KICK, 0);
    check("R3 locked kick ignored", 32'(irq), 1);
    wr(A_LOCK, KEY);
    wr(A_KICK, 0);
    check("R7 kick clears irq", 32'(irq), 0);
    wr(A_CTRL, 0);

    // R7 kicks faster than the timeout keep irq low
    wr(A_LOAD, 3);
    wr(A_CTRL, 1);
    v = 0;
    for (int k = 0; k < 10; k++) begin
      wait_cyc(40);
      if (irq) v = 1;
      wr(A_KICK, 32'hFFFF_FFFF);
    end
    check("R7 periodic kick keeps irq low", v, 0);
    wr(A_CTRL, 0);
    wr(A_KICK, 0);

    // R11 R8: immediate expiry path
    wr(A_LOAD, 0);
    wr(A_CTRL, 3);
    wait_cyc(31); check("R11 irq low at 31", 32'(irq), 0);
    wait_cyc(1);  check("R11 irq at 32", 32'(irq), 1);
    wait_cyc(15); check("R11 rst_req low at 47", 32'(srst), 0);
    wait_cyc(1);  check("R11 rst_req at 48", 32'(srst), 1);
    wr(A_CTRL, 0);
    wr(A_KICK, 0);
    wait_cyc(20);
    check("R8 rst_req sticky", 32'(srst), 1);
    check("R10 irq off when stopped", 32'(irq), 0);
    rst_n = 1'b0;
    wait_cyc(1);
    rst_n = 1'b1;
    wait_cyc(1);
    check("R8 rst_req cleared by reset", 32'(srst), 0);
    rd(A_LOCK, v); check("R1 relocked after reset", v, 1);

    finish_run();
  end
endmodule